// File: doc/BRIEF.md
# Isolation Unlock Sequence Gate

This block lives on the always-on side of a power-isolation boundary. Software writes a 3-bit unlock code through a small register port, one value per write. A tracker compares each value with the next expected entry of a fixed seven-value unlock code. After each accepted value it sets an acknowledge bit, so software can confirm the step before it writes the next one.

When the seventh value is accepted, the block raises an isolation-enable output for a fixed number of clock cycles. The cross-domain transfer that software has staged happens inside that window. The window length is a parameter, so the same block serves a real 1 ms window at the system clock and a short window in simulation. While the window is open, the tracker ignores new unlock writes. A wrong value sends the tracker back to the start, except that a zero is taken at once as the first step of a new attempt.

Top module: `iso_unlock_gate`

## Requirements
- R1: After a synchronous active-low reset, the acknowledge bit reads 0, `iso_en` is 0, the stored code reads 0 and the tracker expects the first step.
- R2: A write to the code register (address 0) uses only `wr_data[2:0]`. Bits above 2 have no effect on tracking or on the readback.
- R3: The codes 0, 1, 3, 7, 5, 1, 0, written in that order to address 0, complete the unlock. `iso_en` is high at the first clock edge after the write of the last value.
- R4: After step i (counted from 0) is accepted, the acknowledge bit equals i mod 2. It is visible one clock edge after the write.
- R5: A value that does not match the expected step returns the tracker to the start. A non-zero mismatch leaves the acknowledge bit unchanged. A zero mismatch counts as step 0: the acknowledge bit becomes 0 and the next expected value is 1.
- R6: `iso_en` stays high for exactly `PULSE_CYCLES` clock cycles, then falls.
- R7: While `iso_en` is high, writes to address 0 do not move the tracker, do not change the acknowledge bit and do not restart or extend the window. The tracker is at its start when the window ends.
- R8: Reads are combinational on `rd_addr`. Address 0 returns the last written code in bits [2:0]. Address 1 returns the acknowledge bit in bit 3. Address 2 returns `iso_en` in bit 0. All other bits, and address 3, read 0.
- R9: Writes to addresses other than 0 have no effect on the tracker or on the acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | DATA_W | Write data; only bits [2:0] matter at address 0 |
| rd_addr | input | ADDR_W | Register address for the combinational read |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| iso_en | output | 1 | Isolation-enable window, high for PULSE_CYCLES cycles |

## Verification
Two situations are the hardest to reach from the ports. The first is an unlock write that lands inside an open enable window. The bench sets a short window, completes the code, and at once replays the whole code while the window is still open. It then checks that the acknowledge bit holds, that the window falls exactly on schedule, and that a later write of 1 is treated as a mismatch. The second is a zero written in the middle of an attempt. The bench reaches it by aborting a partial code with 0 and then finishing the unlock from that zero.

// File: rtl/iso_unlock_pkg.sv
// Shared constants for the isolation unlock gate: register offsets,
// status bit positions and the fixed unlock code.
// Assumes the code field is 3 bits and the code has seven steps.
package iso_unlock_pkg;

    localparam int unsigned CODE_W   = 3;
    localparam int unsigned SEQ_LEN  = 7;
    localparam int unsigned STEP_W   = $clog2(SEQ_LEN);

    localparam int unsigned OFF_CODE = 0;
    localparam int unsigned OFF_ACK  = 1;
    localparam int unsigned OFF_EN   = 2;

    localparam int unsigned ACK_BIT  = 3;
    localparam int unsigned EN_BIT   = 0;

    // Expected code value at a given step of the unlock sequence.
    function automatic logic [CODE_W-1:0] unlock_code(input logic [STEP_W-1:0] step);
        logic [CODE_W-1:0] v;
        case (step)
            3'd0:    v = 3'd0;
            3'd1:    v = 3'd1;
            3'd2:    v = 3'd3;
            3'd3:    v = 3'd7;
            3'd4:    v = 3'd5;
            3'd5:    v = 3'd1;
            3'd6:    v = 3'd0;
            default: v = 3'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/iso_reg_port.sv
// Register port of the unlock gate. It decodes writes to the code
// register into a one-cycle strobe, keeps the last written code for
// readback, and multiplexes the status bits onto the read bus.
// Assumes DATA_W >= 4 and one write per cycle at most.
module iso_reg_port
    import iso_unlock_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ack,
    input  logic              iso_en,
    output logic              code_stb,
    output logic [CODE_W-1:0] code_val,
    output logic [DATA_W-1:0] rd_data
);

    logic [CODE_W-1:0] code_q;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

    // Decode a write to the code register into a strobe and value.
    always_comb begin
        code_stb = wr_en && (wr_addr == ADDR_W'(OFF_CODE));
        code_val = wr_data[CODE_W-1:0];
    end

    // Keep the last written code for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (code_stb)
            code_q <= code_val;
    end

    // Select the read data from the stored code and the status bits.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFF_CODE))
            rd_data[CODE_W-1:0] = code_q;
        else if (rd_addr == ADDR_W'(OFF_ACK))
            rd_data[ACK_BIT] = ack;
        else if (rd_addr == ADDR_W'(OFF_EN))
            rd_data[EN_BIT] = iso_en;
    end

endmodule

// File: rtl/iso_seq_tracker.sv
// Unlock sequence tracker. It compares each code strobe with the
// expected step, drives the acknowledge bit and signals completion.
// Assumes the busy input is high for the whole enable window.
module iso_seq_tracker
    import iso_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_stb,
    input  logic [CODE_W-1:0] code_val,
    input  logic              busy,
    output logic              ack,
    output logic              done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    logic [STEP_W-1:0] step_q;
    logic              take;
    logic              hit;

    // Qualify the strobe and compare the value with the expected step.
    always_comb begin
        take = code_stb && !busy;
        hit  = (code_val == unlock_code(step_q));
        done = take && hit && (step_q == LAST_STEP);
    end

    // Advance, restart or hold the step index and the acknowledge bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            ack    <= 1'b0;
        end else if (take) begin
            if (hit) begin
                ack    <= step_q[0];
                step_q <= (step_q == LAST_STEP) ? '0 : step_q + 1'b1;
            end else if (code_val == '0) begin
                ack    <= 1'b0;
                step_q <= STEP_W'(1);
            end else begin
                step_q <= '0;
            end
        end
    end

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ack) && $stable(step_q)));

    p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !code_stb |=> $stable(ack));

    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_q < STEP_W'(SEQ_LEN));

    p_done_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (step_q == '0));

endmodule

// File: rtl/iso_pulse_timer.sv
// Enable window timer. A start pulse loads the counter with the window
// length; the output is high while the counter is non-zero.
// Assumes start never arrives while the window is open.
module iso_pulse_timer #(
    parameter int unsigned PULSE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(PULSE_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Drive the window from the counter state.
    always_comb active = (cnt_q != '0);

    p_start_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !start);

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/iso_unlock_gate.sv
// Top of the isolation unlock gate. It joins the register port, the
// sequence tracker and the window timer. The enable output is high for
// PULSE_CYCLES cycles after a complete unlock code.
// Assumes a single clock domain on the always-on side.
module iso_unlock_gate
    import iso_unlock_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned ADDR_W       = 2,
    parameter int unsigned PULSE_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              iso_en
);

    logic              code_stb;
    logic [CODE_W-1:0] code_val;
    logic              ack;
    logic              done;

    iso_reg_port #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .ack      (ack),
        .iso_en   (iso_en),
        .code_stb (code_stb),
        .code_val (code_val),
        .rd_data  (rd_data)
    );

    iso_seq_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_stb (code_stb),
        .code_val (code_val),
        .busy     (iso_en),
        .ack      (ack),
        .done     (done)
    );

    iso_pulse_timer #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (done),
        .active (iso_en)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!iso_en && !ack));

endmodule

// File: tb/sim_iso_unlock_gate.sv
module sim_iso_unlock_gate;

    localparam int unsigned P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        iso_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int          kind;
        logic [1:0]  addr;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    iso_unlock_gate #(.DATA_W(16), .ADDR_W(2), .PULSE_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .iso_en(iso_en)
    );

    // Monitor: pops expected items and compares them with the design.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                #1;
                got = (it.kind == 0) ? rd_data : {15'b0, iso_en};
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic exp_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
        item_t it;
        it.kind = 0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_pin(input logic e, input string tag);
        item_t it;
        it.kind = 1; it.addr = 2'd0; it.exp = {15'b0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One code write followed by a check of the acknowledge bit.
    task automatic step(input logic [15:0] d, input logic ack, input string tag);
        wr(2'd0, d);
        exp_reg(2'd1, {12'b0, ack, 3'b0}, tag);
        settle();
    endtask

    task automatic full_code(input string tag);
        step(16'd0, 1'b0, tag);
        step(16'd1, 1'b1, tag);
        step(16'd3, 1'b0, tag);
        step(16'd7, 1'b1, tag);
        step(16'd5, 1'b0, tag);
        step(16'd1, 1'b1, tag);
        step(16'd0, 1'b0, tag);
    endtask

    // Driver: applies stimulus and pushes expectations.
    initial begin
        idle(3);
        rst_n = 1'b1;
        exp_reg(2'd1, 16'h0000, "R1 ack after reset");
        exp_reg(2'd2, 16'h0000, "R1 enable status after reset");
        exp_reg(2'd0, 16'h0000, "R1 code after reset");
        exp_pin(1'b0, "R1 iso_en after reset");
        exp_reg(2'd3, 16'h0000, "R8 unused address reads zero");
        settle();

        // R3 / R4: full code, parity acknowledge per step
        full_code("R4 step parity");
        exp_pin(1'b1, "R3 iso_en after last step");
        exp_reg(2'd2, 16'h0001, "R8 enable status bit 0");
        exp_reg(2'd0, 16'h0000, "R8 code readback");
        settle();
        // R6: window length
        idle(P - 1);
        exp_pin(1'b1, "R6 iso_en in last window cycle");
        settle();
        idle(1);
        exp_pin(1'b0, "R6 iso_en after window");
        exp_reg(2'd2, 16'h0000, "R8 enable status clears");
        settle();

        // R7: writes during the window are ignored
        full_code("R4 second unlock");
        exp_pin(1'b1, "R3 second unlock");
        settle();
        step(16'd0, 1'b0, "R7 write during window");
        step(16'd1, 1'b0, "R7 write during window");
        step(16'd3, 1'b0, "R7 write during window");
        step(16'd7, 1'b0, "R7 write during window");
        step(16'd5, 1'b0, "R7 write during window");
        step(16'd1, 1'b0, "R7 write during window");
        step(16'd0, 1'b0, "R7 write during window");
        idle(P - 1 - 14);
        exp_pin(1'b1, "R7 window not restarted, still high");
        settle();
        idle(1);
        exp_pin(1'b0, "R7 window not extended");
        settle();
        step(16'd1, 1'b0, "R7 tracker at start after window");

        // R5: mismatches
        step(16'd0, 1'b0, "R5 step0");
        step(16'd1, 1'b1, "R5 step1");
        step(16'd6, 1'b1, "R5 nonzero mismatch keeps ack");
        step(16'd3, 1'b1, "R5 tracker restarted");
        step(16'd0, 1'b0, "R5 restart step0");
        step(16'd1, 1'b1, "R5 restart step1");
        step(16'd0, 1'b0, "R5 zero mismatch is step0");
        step(16'd1, 1'b1, "R5 continue after zero");
        step(16'd3, 1'b0, "R5 continue");
        step(16'd7, 1'b1, "R5 continue");
        step(16'd5, 1'b0, "R5 continue");
        step(16'd1, 1'b1, "R5 continue");
        step(16'd0, 1'b0, "R5 continue");
        exp_pin(1'b1, "R5 unlock after zero restart");
        settle();
        idle(P + 2);

        // R2: upper data bits ignored
        step(16'hFFF8, 1'b0, "R2 upper bits step0");
        step(16'h0009, 1'b1, "R2 upper bits step1");
        exp_reg(2'd0, 16'h0001, "R2 readback only low bits");
        settle();

        // R9: writes to other addresses do not touch the tracker
        wr(2'd1, 16'h0003);
        exp_reg(2'd1, 16'h0008, "R9 ack write ignored");
        settle();
        wr(2'd2, 16'h0007);
        exp_reg(2'd1, 16'h0008, "R9 status write ignored");
        exp_pin(1'b0, "R9 status write no enable");
        settle();
        step(16'h5503, 1'b0, "R9 tracker still at step2");
        step(16'hA007, 1'b1, "R2 step3");
        step(16'h0105, 1'b0, "R2 step4");
        step(16'hFF01, 1'b1, "R2 step5");
        step(16'h8000, 1'b0, "R2 step6");
        exp_pin(1'b1, "R2 unlock with upper bits set");
        settle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule